// File: doc/BRIEF.md
# Dual-width fetch and branch controller

This block is the program-control front end of a four-stage pipeline (Fetch, Decode, Execute, Writeback). The pipeline runs either compact 16-bit or wide 32-bit instructions, and both formats sit in one 32-bit-wide instruction memory. The program counter counts halfwords. Its upper bits address the memory word, and in compact mode its low bit picks the half of the word that moves on to Decode.

In Decode the block recognises its own control instructions and picks the next fetch address. Control instructions cover jumps, calls, returns, sleep and loading the loop counter. On a taken transfer it turns the instruction already fetched into a bubble. Conditions whose flag belongs to the instruction just ahead resolve one cycle later, in Execute. The block also keeps an eight-entry return stack with a sticky error flag and a loop counter. The datapath supplies condition flags and decodes all other instructions.

Top module: `dualfmt_fetch_ctl`

## Requirements
- R1: While `rst_n` is low, `dec_valid` and `rs_err` are 0 and `imem_addr` is 0. The first instruction decoded after reset is the one at PC 0.
- R2: `imem_addr` equals PC shifted right by one. In compact mode (`wide_mode`=0), an even PC delivers `imem_rdata[31:16]` and an odd PC delivers `imem_rdata[15:0]`. Either half appears on `dec_instr[15:0]`, with `dec_instr[31:16]` at 0.
- R3: Sequential flow adds 1 to the PC in compact mode and 2 in wide mode. In wide mode all 32 bits of the word reach `dec_instr`.
- R4: A control instruction has its three top format bits at 111. In compact mode the fields are: op at [12:10], condition at [9:8], immediate at [7:0]. In wide mode: op at [28:26], condition at [25:24], immediate at [15:0]. Ops are 0 jump, 1 call, 2 return, 3 sleep, 4 load loop counter. Conditions are 0 always, 1 counter, 2 early flag (`flag_early` in the Decode cycle), 3 late flag. Any other word never changes the flow.
- R5: A jump or call taken on an always, counter or early condition leaves exactly one invalid Decode cycle before its target. The target is PC + sext(imm8) + 1 in compact mode and PC + sext(imm16) in wide mode. A transfer that is not taken costs no cycle.
- R6: A late-condition transfer holds the fetch address and is resolved one cycle later from `flag_late`. If taken it leaves two invalid Decode cycles. If not taken it leaves one, and the next sequential instruction follows.
- R7: A taken call pushes PC + step. A taken return sends the PC to the top of the stack, pops it and leaves one invalid Decode cycle.
- R8: Op 4 loads the loop counter from the immediate. The counter condition is true while the counter is nonzero, and every transfer taken on it decrements the counter by one.
- R9: Sleep (op 3) holds the fetch address and keeps `dec_valid` low until `wake` is seen high. The next sequential instruction is decoded on the following cycle.
- R10: The return stack holds 8 entries. A push while full drops the address but still jumps. A return while empty falls through sequentially. Either case sets `rs_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects 32-bit instructions, 0 selects 16-bit |
| imem_addr | output | PCW-1 | Word address into instruction memory |
| imem_rdata | input | 32 | Word read combinationally at `imem_addr` |
| flag_early | input | 1 | Condition flag valid in the Decode cycle |
| flag_late | input | 1 | Condition flag valid one cycle after Decode |
| wake | input | 1 | Ends a sleep |
| dec_valid | output | 1 | Decode stage holds a real instruction |
| dec_pc | output | PCW | Halfword PC of the Decode instruction |
| dec_instr | output | 32 | Instruction in Decode |
| rs_err | output | 1 | Sticky return-stack overflow or underflow |

## Verification
Every result appears one register later than the edge at which its stimulus is sampled. The PC in Decode, the bubbles, the loop-counter decisions and the stack error all change at the edge that ends the Decode cycle of the control instruction. A late flag is used at the following edge, and `wake` takes effect at the edge where it is first high. The bench sets inputs at a falling edge, lets one rising edge pass, and compares `dec_valid`, `dec_pc`, `dec_instr` and `rs_err` at the next falling edge. Each row of the cycle table therefore lines up with exactly one edge.

// File: rtl/dualfmt_fetch_ctl.sv
module dualfmt_fetch_ctl #(
  parameter int PCW = 16,
  parameter int LCW = 16,
  parameter int RSD = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wide_mode,
  output logic [PCW-2:0] imem_addr,
  input  logic [31:0]    imem_rdata,
  input  logic           flag_early,
  input  logic           flag_late,
  input  logic           wake,
  output logic           dec_valid,
  output logic [PCW-1:0] dec_pc,
  output logic [31:0]    dec_instr,
  output logic           rs_err
);
  localparam int SPW = $clog2(RSD + 1);
  localparam int IW  = (RSD > 1) ? $clog2(RSD) : 1;
  localparam logic [2:0] OP_JMP = 3'd0, OP_CALL = 3'd1, OP_RET = 3'd2,
                         OP_SLEEP = 3'd3, OP_LDLC = 3'd4;
  localparam logic [1:0] C_ALW = 2'd0, C_CNT = 2'd1, C_ERL = 2'd2, C_LATE = 2'd3;

  logic [PCW-1:0] pc_f, pc_d;
  logic           vld_d;
  logic [31:0]    ir_d;
  logic           sleep_q, lp_valid;
  logic [2:0]     lp_op;
  logic [PCW-1:0] lp_target, lp_link;
  logic [LCW-1:0] lc;
  logic [PCW-1:0] stk [RSD];
  logic [SPW-1:0] sp;
  logic           err_q;

  wire [PCW-1:0] step = wide_mode ? PCW'(2) : PCW'(1);

  assign imem_addr = pc_f[PCW-1:1];
  wire [31:0] fetched = wide_mode ? imem_rdata
                      : {16'h0, pc_f[0] ? imem_rdata[15:0] : imem_rdata[31:16]};

  wire       is_ctrl = vld_d && ((wide_mode ? ir_d[31:29] : ir_d[15:13]) == 3'b111);
  wire [2:0] op  = wide_mode ? ir_d[28:26] : ir_d[12:10];
  wire [1:0] cnd = wide_mode ? ir_d[25:24] : ir_d[9:8];
  wire       xfer = (op == OP_JMP) || (op == OP_CALL) || (op == OP_RET);

  wire [PCW-1:0] off = wide_mode ? PCW'($signed(ir_d[15:0]))
                                 : PCW'($signed(ir_d[7:0])) + PCW'(1);
  wire [PCW-1:0] d_target = pc_d + off;
  wire [PCW-1:0] d_link   = pc_d + step;
  wire [LCW-1:0] lc_imm   = wide_mode ? LCW'(ir_d[15:0]) : LCW'(ir_d[7:0]);

  logic cond_now;
  always_comb begin
    case (cnd)
      C_ALW:   cond_now = 1'b1;
      C_CNT:   cond_now = (lc != '0);
      C_ERL:   cond_now = flag_early;
      default: cond_now = 1'b0;
    endcase
  end

  wire is_late   = is_ctrl && xfer && (cnd == C_LATE);
  wire taken_now = is_ctrl && xfer && (cnd != C_LATE) && cond_now;
  wire is_sleep  = is_ctrl && (op == OP_SLEEP);
  wire is_ldlc   = is_ctrl && (op == OP_LDLC);

  wire           go       = lp_valid ? flag_late : taken_now;
  wire [2:0]     r_op     = lp_valid ? lp_op : op;
  wire [PCW-1:0] r_target = lp_valid ? lp_target : d_target;
  wire [PCW-1:0] r_link   = lp_valid ? lp_link : d_link;

  wire stk_full  = (sp == SPW'(RSD));
  wire stk_empty = (sp == '0);
  wire do_call   = go && (r_op == OP_CALL);
  wire do_ret    = go && (r_op == OP_RET);
  wire redirect  = go && !(r_op == OP_RET && stk_empty);
  wire [PCW-1:0] stk_top = stk[IW'(sp - SPW'(1))];
  wire [PCW-1:0] next_tgt = (r_op == OP_RET) ? stk_top : r_target;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_f      <= '0;
      pc_d      <= '0;
      vld_d     <= 1'b0;
      ir_d      <= '0;
      sleep_q   <= 1'b0;
      lp_valid  <= 1'b0;
      lp_op     <= '0;
      lp_target <= '0;
      lp_link   <= '0;
      lc        <= '0;
      sp        <= '0;
      err_q     <= 1'b0;
    end else begin
      lp_valid <= 1'b0;
      if (sleep_q && !wake) begin
        vld_d <= 1'b0;
      end else if (redirect) begin
        pc_f  <= next_tgt;
        vld_d <= 1'b0;
      end else if (is_late) begin
        vld_d     <= 1'b0;
        lp_valid  <= 1'b1;
        lp_op     <= op;
        lp_target <= d_target;
        lp_link   <= d_link;
      end else if (is_sleep) begin
        sleep_q <= 1'b1;
        vld_d   <= 1'b0;
      end else begin
        sleep_q <= 1'b0;
        pc_f    <= pc_f + step;
        pc_d    <= pc_f;
        ir_d    <= fetched;
        vld_d   <= 1'b1;
      end

      if (is_ldlc)
        lc <= lc_imm;
      else if (taken_now && cnd == C_CNT)
        lc <= lc - LCW'(1);

      if (do_call) begin
        if (stk_full) err_q <= 1'b1;
        else          sp <= sp + SPW'(1);
      end else if (do_ret) begin
        if (stk_empty) err_q <= 1'b1;
        else           sp <= sp - SPW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && do_call && !stk_full)
      stk[IW'(sp)] <= r_link;
  end

  assign dec_valid = vld_d;
  assign dec_pc    = pc_d;
  assign dec_instr = ir_d;
  assign rs_err    = err_q;
endmodule

// File: rtl/dualfmt_fetch_ctl_chk.sv
module dualfmt_fetch_ctl_chk #(
  parameter int PCW = 16,
  parameter int RSD = 8,
  parameter int SPW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wide_mode,
  input logic           wake,
  input logic [PCW-2:0] imem_addr,
  input logic           dec_valid,
  input logic [PCW-1:0] dec_pc,
  input logic           rs_err,
  input logic           is_ctrl,
  input logic           sleep_q,
  input logic           lp_valid,
  input logic           redirect,
  input logic [SPW-1:0] sp
);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rs_err |=> rs_err);

  p_sp_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(RSD));

  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && !wake) |=> (!dec_valid && $stable(imem_addr)));

  p_redirect_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !dec_valid);

  p_late_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lp_valid |-> !dec_valid);

  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !is_ctrl) |=>
      (dec_valid && dec_pc == $past(dec_pc) + ($past(wide_mode) ? PCW'(2) : PCW'(1))));
endmodule

bind dualfmt_fetch_ctl dualfmt_fetch_ctl_chk #(.PCW(PCW), .RSD(RSD), .SPW($clog2(RSD + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .wake(wake),
  .imem_addr(imem_addr), .dec_valid(dec_valid), .dec_pc(dec_pc), .rs_err(rs_err),
  .is_ctrl(is_ctrl), .sleep_q(sleep_q), .lp_valid(lp_valid),
  .redirect(redirect), .sp(sp)
);

// File: tb/dualfmt_fetch_ctl_tb.sv
module dualfmt_fetch_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic [14:0] imem_addr;
  logic [31:0] imem_rdata;
  logic        flag_early = 1'b0, flag_late = 1'b0, wake = 1'b0;
  logic        dec_valid;
  logic [15:0] dec_pc;
  logic [31:0] dec_instr;
  logic        rs_err;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dualfmt_fetch_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .flag_early(flag_early), .flag_late(flag_late), .wake(wake),
    .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_instr(dec_instr), .rs_err(rs_err)
  );

  // compact program, halfword-addressed
  localparam logic [15:0] P16 [18] = '{
    16'h0001, 16'hF002, 16'h0002, 16'hE1FE, 16'hE405, 16'hE202,
    16'h0006, 16'h0007, 16'hE303, 16'h0009, 16'h000A, 16'hE800,
    16'hE303, 16'hEC00, 16'h000E, 16'hE800, 16'h0010, 16'hE0FF};
  // wide program, word-addressed
  localparam logic [31:0] P32 [5] = '{
    32'h0000_0100, 32'hE400_0006, 32'h0000_0200, 32'h0000_0300, 32'hE400_0000};

  function automatic logic [15:0] half(input int i);
    return (i < 18) ? P16[i] : 16'h0000;
  endfunction

  always_comb begin
    if (wide_mode) imem_rdata = (int'(imem_addr) < 5) ? P32[imem_addr] : 32'h0;
    else           imem_rdata = {half(2 * int'(imem_addr)), half(2 * int'(imem_addr) + 1)};
  end

  // row: [12] wake, [11] flag_early, [10] flag_late, [9] rs_err, [8] dec_valid, [7:0] dec_pc
  localparam int NV = 34;
  localparam logic [12:0] VEC [NV] = '{
    13'h100, 13'h101, 13'h102, 13'h103, 13'h000, 13'h102, 13'h103, 13'h000,
    13'h102, 13'h103, 13'h104, 13'h000, 13'h10A, 13'h10B, 13'h000, 13'h105,
    13'h800, 13'h108, 13'h000, 13'h400, 13'h10C, 13'h000, 13'h10D, 13'h000,
    13'h000, 13'h000, 13'h110E, 13'h10F, 13'h310, 13'h311, 13'h200, 13'h311,
    13'h200, 13'h311};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 3000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 3000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dec_valid == 1'b0, "R1 valid in reset", 32'(dec_valid), 0);
    chk(imem_addr == '0, "R1 fetch address in reset", 32'(imem_addr), 0);
    chk(rs_err == 1'b0, "R1 error in reset", 32'(rs_err), 0);
    rst_n = 1'b1;

    // compact-mode table: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      wake       = VEC[i][12];
      flag_early = VEC[i][11];
      flag_late  = VEC[i][10];
      @(posedge clk);
      @(negedge clk);
      chk(dec_valid == VEC[i][8], $sformatf("R5/R6/R7/R8/R9 valid row %0d", i),
          32'(dec_valid), 32'(VEC[i][8]));
      if (VEC[i][8]) begin
        chk(dec_pc == 16'(VEC[i][7:0]), $sformatf("R3/R5 pc row %0d", i),
            32'(dec_pc), 32'(VEC[i][7:0]));
        chk(dec_instr == {16'h0, half(int'(VEC[i][7:0]))}, $sformatf("R2 half select row %0d", i),
            dec_instr, {16'h0, half(int'(VEC[i][7:0]))});
      end
      chk(rs_err == VEC[i][9], $sformatf("R10 underflow flag row %0d", i),
          32'(rs_err), 32'(VEC[i][9]));
    end
    wake = 1'b0; flag_early = 1'b0; flag_late = 1'b0;

    // wide mode: step of 2, full word, repeated self-call overflows the stack (R3 R10)
    rst_n = 1'b0;
    wide_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk(dec_valid == 1'b0, "R1 valid in reset wide", 32'(dec_valid), 0);
    rst_n = 1'b1;
    for (int e = 1; e <= 20; e++) begin
      logic       ev;
      logic [7:0] ep;
      @(posedge clk);
      @(negedge clk);
      if (e == 1)      begin ev = 1'b1; ep = 8'd0; end
      else if (e == 2) begin ev = 1'b1; ep = 8'd2; end
      else if (e == 3) begin ev = 1'b0; ep = 8'd0; end
      else             begin ev = (e % 2 == 0); ep = 8'd8; end
      chk(dec_valid == ev, $sformatf("R3/R7 wide valid edge %0d", e), 32'(dec_valid), 32'(ev));
      if (ev) begin
        chk(dec_pc == 16'(ep), $sformatf("R3 wide pc edge %0d", e), 32'(dec_pc), 32'(ep));
        chk(dec_instr == P32[ep / 2], $sformatf("R3 wide word edge %0d", e), dec_instr, P32[ep / 2]);
      end
      chk(rs_err == (e >= 19), $sformatf("R10 overflow flag edge %0d", e), 32'(rs_err), 32'(e >= 19));
    end

    // mid-run reset clears everything (R1)
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(dec_valid == 1'b0, "R1 valid after mid-run reset", 32'(dec_valid), 0);
    chk(rs_err == 1'b0, "R1 error after mid-run reset", 32'(rs_err), 0);
    chk(imem_addr == '0, "R1 address after mid-run reset", 32'(imem_addr), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule